// File: doc/BRIEF.md
# End-of-Write Status Read Path

This block sits on the read side of a paged nonvolatile memory. It chooses what the byte-wide data bus carries and when the bus is driven. While an internal programming cycle is running, the memory array cannot be read. During that time an ordinary read returns two status bits instead of stored data.

- Bit 7 carries the inverse of bit 7 of the byte written last.
- Bit 6 changes value on every new read strobe.

Once the programming cycle finishes, reads return the array byte unchanged. Bit 6 then stops changing. The host can poll either bit at any time while the device is busy. It does this through the same strobes it uses for normal reads, so no separate status register is needed.

All control inputs are sampled on the clock. Both the bus value and the bus drive enable are registered, so each appears one cycle after the inputs that select it. A reopening of the read strobe only counts as a new poll when chip-enable was either not the pin that closed the strobe, or was held high for at least `CE_MIN_HIGH` cycles. A shorter release of chip-enable does not count as a new read.

Top module: `eow_status_rd`

## Requirements
- R1: `data_oe_o` is 1 in the cycle after one in which `ce_ni`=0, `oe_ni`=0 and `we_ni`=1. In the cycle after any other combination it is 0. Write-enable low with both enables low is not a read.
- R2: In the cycle after a read sampled with `busy_i`=1, `data_o[7]` equals the inverse of `last_msb_i` from that read cycle.
- R3: While busy, bit 6 of the output inverts once for each new read strobe. A strobe held low across consecutive cycles leaves bit 6 unchanged.
- R4: A new read strobe is a read cycle that follows a non-read cycle. Reopening through `oe_ni` or `we_ni` always counts. Reopening through `ce_ni` counts when chip-enable was high for at least `CE_MIN_HIGH` cycles (default 3).
- R5: If `ce_ni` was high for 1 to `CE_MIN_HIGH`-1 cycles and the strobe then reopens, that reopening is not a new strobe and bit 6 keeps its value.
- R6: In the cycle after a read sampled with `busy_i`=0, `data_o` equals `array_data_i` from that cycle in all eight bits. Strobes seen while not busy do not change the toggle state that the next busy read starts from.
- R7: In the cycle after a busy read, `data_o[5:0]` equals the fixed pattern `BUSY_PAD` (default 6'b010110).
- R8: After reset, `data_oe_o`=0 and `data_o`=0. The toggle state starts at `TOG_RESET` (default 0), so the first busy read after reset returns bit 6 = 1.
- R9: Whenever `data_oe_o` is 0, `data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal programming cycle in progress |
| last_msb_i | input | 1 | Bit 7 of the byte written last |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| array_data_i | input | 8 | Byte read from the memory array |
| data_o | output | 8 | Read data or status byte |
| data_oe_o | output | 1 | Drive enable for the tri-state data pads |

## Verification
The bench builds the block with its default parameters. `CE_MIN_HIGH`=3 keeps the chip-enable recovery window short: every release length below, at and above the limit can be reached within a few cycles. A sweep walks all combinations of the three strobes and the busy flag across hundreds of cycle-to-cycle transitions. A running model of the requirements predicts the toggle state, the float state and every data bit. Directed sequences then single out three cases: the first poll after reset, reopening the strobe through output-enable, and chip-enable releases of one cycle and of three cycles.

// File: rtl/eow_status_pkg.sv
package eow_status_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned PAD_W    = TOG_BIT;

  typedef struct packed {
    logic rd;
    logic start;
  } strobe_t;
endpackage

// File: rtl/eow_strobe_detect.sv
module eow_strobe_detect
  import eow_status_pkg::*;
#(
  parameter int unsigned CE_MIN_HIGH = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ce_ni,
  input  logic    oe_ni,
  input  logic    we_ni,
  output strobe_t strobe_o
);
  localparam int unsigned GAP_W = $clog2(CE_MIN_HIGH + 1);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(CE_MIN_HIGH);

  logic             rd;
  logic             rd_q;
  logic             ce_low_q;
  logic [GAP_W-1:0] gap_q;
  logic             ce_ok;

  assign rd    = !ce_ni && !oe_ni && we_ni;
  // reopen via ce only counts after the recovery window
  assign ce_ok = ce_low_q || (gap_q >= GAP_SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= 1'b0;
      ce_low_q <= 1'b0;
      gap_q    <= GAP_SAT;
    end else begin
      rd_q     <= rd;
      ce_low_q <= !ce_ni;
      if (!ce_ni)              gap_q <= '0;
      else if (gap_q < GAP_SAT) gap_q <= gap_q + 1'b1;
    end
  end

  assign strobe_o.rd    = rd;
  assign strobe_o.start = rd && !rd_q && ce_ok;
endmodule

// File: rtl/eow_toggle_gen.sv
module eow_toggle_gen #(
  parameter logic TOG_RESET = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic start_i,
  output logic tog_nxt_o
);
  logic tog_q;

  assign tog_nxt_o = tog_q ^ (busy_i && start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= TOG_RESET;
    else         tog_q <= tog_nxt_o;
  end
endmodule

// File: rtl/eow_out_mux.sv
module eow_out_mux
  import eow_status_pkg::*;
#(
  parameter logic [PAD_W-1:0] BUSY_PAD = 6'b010110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              busy_i,
  input  logic              tog_i,
  input  logic              last_msb_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              oe_q;

  always_comb begin
    data_d = '0;
    if (rd_i) begin
      if (busy_i) begin
        data_d[POLL_BIT]   = !last_msb_i;
        data_d[TOG_BIT]    = tog_i;
        data_d[PAD_W-1:0]  = BUSY_PAD;
      end else begin
        data_d = array_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      oe_q   <= rd_i;
    end
  end

  assign data_o = data_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/eow_status_rd.sv
module eow_status_rd
  import eow_status_pkg::*;
#(
  parameter int unsigned       CE_MIN_HIGH = 3,
  parameter logic              TOG_RESET   = 1'b0,
  parameter logic [PAD_W-1:0]  BUSY_PAD    = 6'b010110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              last_msb_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  strobe_t strobe;
  logic    tog_nxt;

  eow_strobe_detect #(.CE_MIN_HIGH(CE_MIN_HIGH)) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .strobe_o (strobe)
  );

  eow_toggle_gen #(.TOG_RESET(TOG_RESET)) u_toggle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .start_i   (strobe.start),
    .tog_nxt_o (tog_nxt)
  );

  eow_out_mux #(.BUSY_PAD(BUSY_PAD)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (strobe.rd),
    .busy_i     (busy_i),
    .tog_i      (tog_nxt),
    .last_msb_i (last_msb_i),
    .array_i    (array_data_i),
    .data_o     (data_o),
    .oe_o       (data_oe_o)
  );
endmodule

// File: rtl/eow_status_rd_chk.sv
module eow_status_rd_chk
  import eow_status_pkg::*;
#(
  parameter logic [PAD_W-1:0] BUSY_PAD = 6'b010110
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              last_msb_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic rd_now;
  logic rd_d;
  logic busy_d;

  assign rd_now = !ce_ni && !oe_ni && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_d   <= 1'b0;
      busy_d <= 1'b0;
    end else begin
      rd_d   <= rd_now;
      busy_d <= busy_i;
    end
  end

  AST_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_now |=> data_oe_o); // R1
  AST_FLOAT_OFF_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_now |=> !data_oe_o); // R1
  AST_POLL_INVERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_now && busy_i) |=> (data_o[POLL_BIT] == !$past(last_msb_i))); // R2
  AST_TOG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_now && rd_d && busy_i && busy_d) |=> $stable(data_o[TOG_BIT])); // R3
  AST_TRUE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_now && !busy_i) |=> (data_o == $past(array_data_i))); // R6
  AST_PAD_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_now && busy_i) |=> (data_o[PAD_W-1:0] == BUSY_PAD)); // R7
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R9
endmodule

bind eow_status_rd eow_status_rd_chk #(.BUSY_PAD(BUSY_PAD)) u_chk (.*);

// File: tb/eow_status_rd_test.sv
`timescale 1ns/1ps
module eow_status_rd_test;
  localparam int   CE_MIN = 3;
  localparam logic TOG_RST = 1'b0;
  localparam logic [5:0] PAD = 6'b010110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, lmsb = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] arr = '0;
  logic [7:0] data_o;
  logic       data_oe_o;

  int total = 0, failed = 0;
  logic       exp_oe = 1'b0, exp_busy = 1'b0;
  logic [7:0] exp_data = '0;
  logic       m_tog = TOG_RST, m_rd = 1'b0, m_ce_low = 1'b0;
  int         m_gap = CE_MIN;
  logic       last_b6 = 1'b0;
  logic       b6_a;

  always #2.5 clk = ~clk;

  eow_status_rd uut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .last_msb_i(lmsb),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .array_data_i(arr),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  task automatic check(input string tag, input logic ok, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic compare();
    string tag;
    check("R1 drive enable", data_oe_o === exp_oe, {7'd0, data_oe_o}, {7'd0, exp_oe});
    if (!exp_oe) tag = "R9 idle bus";
    else if (!exp_busy) tag = "R6 array data";
    else if (data_o[7] !== exp_data[7]) tag = "R2 inverted poll bit";
    else if (data_o[6] !== exp_data[6]) tag = "R3 toggle bit";
    else tag = "R7 pad bits";
    check(tag, data_o === exp_data, data_o, exp_data);
    last_b6 = data_o[6];
  endtask

  task automatic cyc(input logic ce, input logic oe, input logic we, input logic bz,
                     input logic [7:0] a, input logic lm);
    logic rd, start;
    @(negedge clk);
    compare();
    ce_n = ce; oe_n = oe; we_n = we; busy = bz; arr = a; lmsb = lm;
    rd    = !ce && !oe && we;
    start = rd && !m_rd && (m_ce_low || m_gap >= CE_MIN);
    if (bz && start) m_tog = ~m_tog;
    exp_oe   = rd;
    exp_busy = bz;
    exp_data = !rd ? 8'h00 : (bz ? {~lm, m_tog, PAD} : a);
    m_rd     = rd;
    m_ce_low = !ce;
    if (!ce) m_gap = 0; else if (m_gap < CE_MIN) m_gap++;
  endtask

  initial begin
    #2_000_000;
    total++; failed++;
    $display("FAIL all watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset drive enable", data_oe_o === 1'b0, {7'd0, data_oe_o}, 8'h00);
    check("R8 reset data", data_o === 8'h00, data_o, 8'h00);
    rst_n = 1'b1;
    // first busy poll after reset
    cyc(1, 1, 1, 1, 8'h00, 1'b0);
    cyc(0, 0, 1, 1, 8'h3c, 1'b1);
    cyc(0, 0, 1, 1, 8'h3c, 1'b1);
    check("R8 first poll toggle", last_b6 === ~TOG_RST, {7'd0, last_b6}, {7'd0, ~TOG_RST});
    // R4: reopen through oe flips
    b6_a = last_b6;
    cyc(0, 1, 1, 1, 8'h11, 1'b0);
    cyc(0, 0, 1, 1, 8'h11, 1'b0);
    cyc(0, 0, 1, 1, 8'h11, 1'b0);
    check("R4 oe reopen flips", last_b6 === ~b6_a, {7'd0, last_b6}, {7'd0, ~b6_a});
    // R5: one-cycle ce release does not count
    b6_a = last_b6;
    cyc(1, 0, 1, 1, 8'h22, 1'b1);
    cyc(0, 0, 1, 1, 8'h22, 1'b1);
    cyc(0, 0, 1, 1, 8'h22, 1'b1);
    check("R5 short ce release", last_b6 === b6_a, {7'd0, last_b6}, {7'd0, b6_a});
    // R4: ce release of CE_MIN cycles counts
    b6_a = last_b6;
    for (int k = 0; k < CE_MIN; k++) cyc(1, 0, 1, 1, 8'h33, 1'b0);
    cyc(0, 0, 1, 1, 8'h33, 1'b0);
    cyc(0, 0, 1, 1, 8'h33, 1'b0);
    check("R4 long ce release flips", last_b6 === ~b6_a, {7'd0, last_b6}, {7'd0, ~b6_a});
    // R6: idle strobes do not move toggle
    b6_a = last_b6;
    cyc(0, 1, 1, 0, 8'h5a, 1'b0);
    cyc(0, 0, 1, 0, 8'h5a, 1'b0);
    cyc(0, 1, 1, 0, 8'ha5, 1'b0);
    cyc(0, 0, 1, 0, 8'ha5, 1'b0);
    cyc(0, 1, 1, 1, 8'h00, 1'b0);
    cyc(0, 0, 1, 1, 8'h00, 1'b0);
    cyc(0, 0, 1, 1, 8'h00, 1'b0);
    check("R6 toggle frozen while idle", last_b6 === ~b6_a, {7'd0, last_b6}, {7'd0, ~b6_a});
    // near-exhaustive sweep of strobe and busy transitions
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] v;
      v = 10'(i) ^ 10'(i >> 4) ^ 10'(i * 7);
      cyc(v[0] & v[5], v[1], v[2] | v[6], v[3] | v[7], 8'(i * 29 + 3), v[4] ^ v[8]);
    end
    cyc(1, 1, 1, 0, 8'h00, 1'b0);
    cyc(1, 1, 1, 0, 8'h00, 1'b0);
    summary();
    $finish;
  end
endmodule